// File: doc/BRIEF.md
# Reorder Buffer with In-Order Commit

This block keeps every in-flight instruction of a speculative out-of-order core in a circular queue ordered as the program issued it. An entry is taken at the tail when an instruction issues. It records the instruction class and the destination register, and later it gains a result value, a store address and a branch outcome. Functional units broadcast results on a shared result bus, each tagged with the entry number it belongs to. The buffer, not the register file, listens to that bus and fills whichever of its waiting entries the tag names.

Entries leave only from the head, and only once their results are complete. A retiring arithmetic entry writes the architectural register file inside the block. A retiring store is released to memory through the store port, which is the only path by which a store reaches memory. A retiring branch that was resolved as mispredicted empties the whole buffer, clears all rename state and signals a redirect carrying the correct target. The block also holds the register status table, a busy bit plus an entry tag for each register. Through it, an operand lookup at issue returns either a value or the entry that will produce it.

Top module: `reorder_buf`

## Requirements
- R1: An accepted issue takes the entry named on `issue_tag_o`. Tags run 0,1,2,... in issue order modulo the depth.
- R2: When all entries are occupied, `issue_ready_o` is low and an issue request is dropped without changing any state.
- R3: A result bus beat fills only the entry its tag names, and only if that entry is occupied and still waiting. Beats for free or already completed entries are ignored. The same rule applies to the store-address port.
- R4: The head retires only when complete. The class encoding is 0 = arithmetic, 1 = store, 2 or 3 = branch. Arithmetic and branch entries need their result beat. A store needs both its data beat and its address.
- R5: Retirement is strictly in order. A completed entry behind an incomplete head does not retire.
- R6: Retiring an arithmetic entry pulses `wb_en_o` with its register and value in that cycle. The register file holds the value from the next cycle on.
- R7: `st_en_o` pulses only in the cycle a store retires, with its captured address and data.
- R8: A branch retires as mispredicted when `cdb_mispred_i` was 1 on its result beat. That cycle it raises `flush_o`, with `redirect_pc_o` equal to the beat's value. From the next cycle the buffer is empty and no register is busy. An issue request in the flush cycle is dropped.
- R9: A retiring arithmetic entry clears its register's busy bit only if the register's tag still names that entry. A younger writer keeps the register busy.
- R10: Lookup of `look_reg_i` works as follows. For a register that is not busy, it returns ready with the register file value. For a busy register whose producer has completed, it returns ready with the buffered value. For a busy register whose producer's beat is on the result bus this cycle, it returns ready with the bus value. Otherwise it returns not ready, and `look_tag_o` names the producing entry.
- R11: After reset the buffer is empty, `issue_ready_o` is high, all registers read ready with value 0, and no retire output is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | Issue request |
| issue_kind_i | input | 2 | Instruction class (0 arith, 1 store, 2/3 branch) |
| issue_dst_i | input | REG_W | Destination register of an arithmetic instruction |
| issue_ready_o | output | 1 | Buffer has a free entry |
| issue_tag_o | output | TAG_W | Entry number an issue this cycle receives |
| look_reg_i | input | REG_W | Register looked up for an operand |
| look_ready_o | output | 1 | Operand value available |
| look_val_o | output | DATA_W | Operand value when ready |
| look_tag_o | output | TAG_W | Producing entry when busy |
| cdb_valid_i | input | 1 | Result bus beat |
| cdb_tag_i | input | TAG_W | Entry the beat belongs to |
| cdb_val_i | input | DATA_W | Result value, store data or branch target |
| cdb_mispred_i | input | 1 | Branch resolved as mispredicted |
| agen_valid_i | input | 1 | Store address beat |
| agen_tag_i | input | TAG_W | Entry the address belongs to |
| agen_addr_i | input | ADDR_W | Store address |
| wb_en_o | output | 1 | Register write at retire |
| wb_reg_o | output | REG_W | Register written |
| wb_val_o | output | DATA_W | Value written |
| st_en_o | output | 1 | Store released to memory |
| st_addr_o | output | ADDR_W | Store address |
| st_data_o | output | DATA_W | Store data |
| flush_o | output | 1 | Mispredicted branch retired, buffer flushed |
| redirect_pc_o | output | DATA_W | Correct fetch target |

## Verification
Retire outputs are combinational from the head entry, so a corrupted head pointer, completion flag or stored value shows on `wb_*`, `st_*` or `flush_o` in the same cycle the head becomes complete. A wrong busy bit or tag in the status table shows on the next lookup of that register. That lookup is made every cycle, and it returns either a stale value or a missing producer tag. A lost or extra entry changes the tag sequence on `issue_tag_o` and the point where `issue_ready_o` drops, both visible from the next issue on.

// File: rtl/rob_pkg.sv
`timescale 1ns/1ps
package rob_pkg;
  typedef enum logic [1:0] {
    K_ALU    = 2'd0,
    K_STORE  = 2'd1,
    K_BRANCH = 2'd2,
    K_BRX    = 2'd3
  } kind_e;

  function automatic logic is_branch(input logic [1:0] k);
    return k[1];
  endfunction
endpackage

// File: rtl/rob_ptrs.sv
`timescale 1ns/1ps
module rob_ptrs #(
  parameter int DEPTH = 8,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = TAG_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             flush_i,
  output logic [TAG_W-1:0] head_o,
  output logic [TAG_W-1:0] tail_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o
);
  logic [TAG_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      // flush always coincides with retiring the branch at head
      head_q <= head_q + TAG_W'(1);
      tail_q <= head_q + TAG_W'(1);
      cnt_q  <= '0;
    end else begin
      if (pop_i)  head_q <= head_q + TAG_W'(1);
      if (push_i) tail_q <= tail_q + TAG_W'(1);
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  assign head_o = head_q;
  assign tail_o = tail_q;
  assign cnt_o  = cnt_q;
  assign full_o = (cnt_q == CNT_W'(DEPTH));
endmodule

// File: rtl/rob_entries.sv
`timescale 1ns/1ps
module rob_entries #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int REG_W  = 4,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [TAG_W-1:0]  alloc_idx_i,
  input  logic [1:0]        alloc_kind_i,
  input  logic [REG_W-1:0]  alloc_dst_i,
  input  logic              cdb_valid_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_val_i,
  input  logic              cdb_mispred_i,
  input  logic              agen_valid_i,
  input  logic [TAG_W-1:0]  agen_tag_i,
  input  logic [ADDR_W-1:0] agen_addr_i,
  input  logic              retire_i,
  input  logic [TAG_W-1:0]  retire_idx_i,
  input  logic              flush_i,
  output logic              vld_o   [DEPTH],
  output logic [1:0]        kind_o  [DEPTH],
  output logic [REG_W-1:0]  dst_o   [DEPTH],
  output logic [DATA_W-1:0] val_o   [DEPTH],
  output logic              done_o  [DEPTH],
  output logic [ADDR_W-1:0] addr_o  [DEPTH],
  output logic              adone_o [DEPTH],
  output logic              mis_o   [DEPTH]
);
  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic hit_alloc, hit_cdb, hit_agen, hit_ret;
    assign hit_alloc = alloc_i && (alloc_idx_i == TAG_W'(e));
    assign hit_cdb   = cdb_valid_i && (cdb_tag_i == TAG_W'(e)) && vld_o[e] && !done_o[e];
    assign hit_agen  = agen_valid_i && (agen_tag_i == TAG_W'(e)) && vld_o[e] && !adone_o[e];
    assign hit_ret   = retire_i && (retire_idx_i == TAG_W'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_o[e]   <= 1'b0;
        kind_o[e]  <= '0;
        dst_o[e]   <= '0;
        val_o[e]   <= '0;
        done_o[e]  <= 1'b0;
        addr_o[e]  <= '0;
        adone_o[e] <= 1'b0;
        mis_o[e]   <= 1'b0;
      end else if (flush_i) begin
        vld_o[e]   <= 1'b0;
        done_o[e]  <= 1'b0;
        adone_o[e] <= 1'b0;
        mis_o[e]   <= 1'b0;
      end else begin
        if (hit_ret) vld_o[e] <= 1'b0;
        if (hit_cdb) begin
          val_o[e]  <= cdb_val_i;
          mis_o[e]  <= cdb_mispred_i;
          done_o[e] <= 1'b1;
        end
        if (hit_agen) begin
          addr_o[e]  <= agen_addr_i;
          adone_o[e] <= 1'b1;
        end
        if (hit_alloc) begin
          vld_o[e]   <= 1'b1;
          kind_o[e]  <= alloc_kind_i;
          dst_o[e]   <= alloc_dst_i;
          done_o[e]  <= 1'b0;
          adone_o[e] <= 1'b0;
          mis_o[e]   <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/rob_regstat.sv
`timescale 1ns/1ps
module rob_regstat #(
  parameter int NREG   = 16,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 3,
  localparam int REG_W = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ren_i,
  input  logic [REG_W-1:0]  ren_reg_i,
  input  logic [TAG_W-1:0]  ren_tag_i,
  input  logic              wb_i,
  input  logic [REG_W-1:0]  wb_reg_i,
  input  logic [TAG_W-1:0]  wb_tag_i,
  input  logic [DATA_W-1:0] wb_val_i,
  input  logic              flush_i,
  output logic [DATA_W-1:0] rf_o   [NREG],
  output logic              busy_o [NREG],
  output logic [TAG_W-1:0]  tag_o  [NREG]
);
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic hit_ren, hit_wb;
    assign hit_ren = ren_i && (ren_reg_i == REG_W'(r));
    assign hit_wb  = wb_i && (wb_reg_i == REG_W'(r));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rf_o[r]   <= '0;
        busy_o[r] <= 1'b0;
        tag_o[r]  <= '0;
      end else begin
        if (hit_wb) rf_o[r] <= wb_val_i;
        if (flush_i) begin
          busy_o[r] <= 1'b0;
        end else if (hit_ren) begin
          busy_o[r] <= 1'b1;
          tag_o[r]  <= ren_tag_i;
        end else if (hit_wb && tag_o[r] == wb_tag_i) begin
          busy_o[r] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/reorder_buf.sv
`timescale 1ns/1ps
module reorder_buf
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int NREG   = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int REG_W = $clog2(NREG),
  localparam int CNT_W = TAG_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_valid_i,
  input  logic [1:0]        issue_kind_i,
  input  logic [REG_W-1:0]  issue_dst_i,
  output logic              issue_ready_o,
  output logic [TAG_W-1:0]  issue_tag_o,
  input  logic [REG_W-1:0]  look_reg_i,
  output logic              look_ready_o,
  output logic [DATA_W-1:0] look_val_o,
  output logic [TAG_W-1:0]  look_tag_o,
  input  logic              cdb_valid_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_val_i,
  input  logic              cdb_mispred_i,
  input  logic              agen_valid_i,
  input  logic [TAG_W-1:0]  agen_tag_i,
  input  logic [ADDR_W-1:0] agen_addr_i,
  output logic              wb_en_o,
  output logic [REG_W-1:0]  wb_reg_o,
  output logic [DATA_W-1:0] wb_val_o,
  output logic              st_en_o,
  output logic [ADDR_W-1:0] st_addr_o,
  output logic [DATA_W-1:0] st_data_o,
  output logic              flush_o,
  output logic [DATA_W-1:0] redirect_pc_o
);
  logic [TAG_W-1:0] head, tail;
  logic [CNT_W-1:0] cnt;
  logic             full, commit, issue_fire;

  logic              e_vld   [DEPTH];
  logic [1:0]        e_kind  [DEPTH];
  logic [REG_W-1:0]  e_dst   [DEPTH];
  logic [DATA_W-1:0] e_val   [DEPTH];
  logic              e_done  [DEPTH];
  logic [ADDR_W-1:0] e_addr  [DEPTH];
  logic              e_adone [DEPTH];
  logic              e_mis   [DEPTH];

  logic [DATA_W-1:0] rf   [NREG];
  logic              busy [NREG];
  logic [TAG_W-1:0]  rtag [NREG];

  // head completion
  logic [1:0] h_kind;
  logic       h_ok;
  assign h_kind  = e_kind[head];
  assign h_ok    = e_vld[head] && e_done[head] &&
                   ((h_kind != K_STORE) || e_adone[head]);
  assign commit  = h_ok;
  assign wb_en_o = commit && (h_kind == K_ALU);
  assign st_en_o = commit && (h_kind == K_STORE);
  assign flush_o = commit && is_branch(h_kind) && e_mis[head];

  assign wb_reg_o      = e_dst[head];
  assign wb_val_o      = e_val[head];
  assign st_addr_o     = e_addr[head];
  assign st_data_o     = e_val[head];
  assign redirect_pc_o = e_val[head];

  assign issue_ready_o = !full;
  assign issue_tag_o   = tail;
  assign issue_fire    = issue_valid_i && !full && !flush_o;

  rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (issue_fire),
    .pop_i   (commit),
    .flush_i (flush_o),
    .head_o  (head),
    .tail_o  (tail),
    .cnt_o   (cnt),
    .full_o  (full)
  );

  rob_entries #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_W(REG_W)
  ) u_ents (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .alloc_i       (issue_fire),
    .alloc_idx_i   (tail),
    .alloc_kind_i  (issue_kind_i),
    .alloc_dst_i   (issue_dst_i),
    .cdb_valid_i   (cdb_valid_i),
    .cdb_tag_i     (cdb_tag_i),
    .cdb_val_i     (cdb_val_i),
    .cdb_mispred_i (cdb_mispred_i),
    .agen_valid_i  (agen_valid_i),
    .agen_tag_i    (agen_tag_i),
    .agen_addr_i   (agen_addr_i),
    .retire_i      (commit),
    .retire_idx_i  (head),
    .flush_i       (flush_o),
    .vld_o         (e_vld),
    .kind_o        (e_kind),
    .dst_o         (e_dst),
    .val_o         (e_val),
    .done_o        (e_done),
    .addr_o        (e_addr),
    .adone_o       (e_adone),
    .mis_o         (e_mis)
  );

  rob_regstat #(.NREG(NREG), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_rstat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ren_i     (issue_fire && (issue_kind_i == K_ALU)),
    .ren_reg_i (issue_dst_i),
    .ren_tag_i (tail),
    .wb_i      (wb_en_o),
    .wb_reg_i  (e_dst[head]),
    .wb_tag_i  (head),
    .wb_val_i  (e_val[head]),
    .flush_i   (flush_o),
    .rf_o      (rf),
    .busy_o    (busy),
    .tag_o     (rtag)
  );

  // operand lookup with same-cycle bus bypass
  logic [TAG_W-1:0] l_tag;
  assign l_tag      = rtag[look_reg_i];
  assign look_tag_o = l_tag;
  always_comb begin
    look_ready_o = 1'b1;
    look_val_o   = rf[look_reg_i];
    if (busy[look_reg_i]) begin
      if (e_done[l_tag]) begin
        look_val_o = e_val[l_tag];
      end else if (cdb_valid_i && cdb_tag_i == l_tag) begin
        look_val_o = cdb_val_i;
      end else begin
        look_ready_o = 1'b0;
        look_val_o   = '0;
      end
    end
  end
endmodule

// File: rtl/reorder_buf_chk.sv
`timescale 1ns/1ps
module reorder_buf_chk #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 3,
  localparam int CNT_W = TAG_W + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             issue_valid_i,
  input logic             issue_ready_o,
  input logic             wb_en_o,
  input logic             st_en_o,
  input logic             flush_o,
  input logic             commit,
  input logic [CNT_W-1:0] cnt,
  input logic [TAG_W-1:0] head
);
  // R2
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CNT_W'(DEPTH));

  // R2
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == CNT_W'(DEPTH) && !commit) |=> cnt == CNT_W'(DEPTH));

  // R1
  issue_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_i && issue_ready_o && !commit) |=> cnt == $past(cnt) + CNT_W'(1));

  // R4
  commit_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |-> cnt != '0);

  // R5
  head_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && !flush_o) |=> head == $past(head) + TAG_W'(1));

  // R8
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> cnt == '0);

  // R7
  retire_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wb_en_o, st_en_o, flush_o}));
endmodule

bind reorder_buf reorder_buf_chk #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .issue_valid_i (issue_valid_i),
  .issue_ready_o (issue_ready_o),
  .wb_en_o       (wb_en_o),
  .st_en_o       (st_en_o),
  .flush_o       (flush_o),
  .commit        (commit),
  .cnt           (cnt),
  .head          (head)
);

// File: tb/reorder_buf_bench.sv
`timescale 1ns/1ps
module reorder_buf_bench;
  localparam int D = 8;
  localparam int NR = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        issue_valid_i = 0;
  logic [1:0]  issue_kind_i = 0;
  logic [3:0]  issue_dst_i = 0;
  logic        issue_ready_o;
  logic [2:0]  issue_tag_o;
  logic [3:0]  look_reg_i = 0;
  logic        look_ready_o;
  logic [31:0] look_val_o;
  logic [2:0]  look_tag_o;
  logic        cdb_valid_i = 0;
  logic [2:0]  cdb_tag_i = 0;
  logic [31:0] cdb_val_i = 0;
  logic        cdb_mispred_i = 0;
  logic        agen_valid_i = 0;
  logic [2:0]  agen_tag_i = 0;
  logic [31:0] agen_addr_i = 0;
  logic        wb_en_o;
  logic [3:0]  wb_reg_o;
  logic [31:0] wb_val_o;
  logic        st_en_o;
  logic [31:0] st_addr_o, st_data_o;
  logic        flush_o;
  logic [31:0] redirect_pc_o;

  always #4 clk_i = ~clk_i;

  reorder_buf u_reorder_buf (.*);

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // reference state
  bit          m_vld[D], m_done[D], m_adone[D], m_mis[D];
  int          m_kind[D], m_dst[D];
  logic [31:0] m_val[D], m_addr[D];
  logic [31:0] m_rf[NR];
  bit          m_busy[NR];
  int          m_tag[NR];
  int          m_head, m_tail, m_cnt;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < D; i++) begin
      m_vld[i] = 0; m_done[i] = 0; m_adone[i] = 0; m_mis[i] = 0;
      m_kind[i] = 0; m_dst[i] = 0; m_val[i] = 0; m_addr[i] = 0;
    end
    for (int r = 0; r < NR; r++) begin
      m_rf[r] = 0; m_busy[r] = 0; m_tag[r] = 0;
    end
    m_head = 0; m_tail = 0; m_cnt = 0;
  endtask

  task automatic step(input bit iv, input int k, input int d,
                      input bit cv, input int ct, input logic [31:0] cval, input bit cmis,
                      input bit av, input int at, input logic [31:0] aaddr, input int lr);
    bit full, hok, e_wb, e_st, e_fl, l_rdy;
    int hk, h, t;
    logic [31:0] l_val;
    @(negedge clk_i);
    issue_valid_i = iv; issue_kind_i = 2'(k); issue_dst_i = 4'(d);
    cdb_valid_i = cv; cdb_tag_i = 3'(ct); cdb_val_i = cval; cdb_mispred_i = cmis;
    agen_valid_i = av; agen_tag_i = 3'(at); agen_addr_i = aaddr;
    look_reg_i = 4'(lr);
    #1;
    full = (m_cnt == D);
    h  = m_head;
    hk = m_kind[h];
    hok = m_vld[h] && m_done[h] && (hk != 1 || m_adone[h]);
    e_wb = hok && hk == 0;
    e_st = hok && hk == 1;
    e_fl = hok && hk >= 2 && m_mis[h];
    // R2
    check(issue_ready_o == !full, "R2 issue_ready", 64'(issue_ready_o), 64'(!full));
    // R1
    if (!full) check(issue_tag_o == 3'(m_tail), "R1 issue_tag", 64'(issue_tag_o), 64'(m_tail));
    // R4 R5 R6
    check(wb_en_o == e_wb && (!e_wb || (wb_reg_o == 4'(m_dst[h]) && wb_val_o == m_val[h])),
          "R4 R5 R6 writeback", {27'd0, wb_en_o, wb_reg_o, wb_val_o},
          {27'd0, e_wb, 4'(m_dst[h]), m_val[h]});
    // R4 R7
    check(st_en_o == e_st && (!e_st || (st_addr_o == m_addr[h] && st_data_o == m_val[h])),
          "R4 R7 store", {st_en_o, st_addr_o[30:0], st_data_o},
          {e_st, m_addr[h][30:0], m_val[h]});
    // R8
    check(flush_o == e_fl && (!e_fl || redirect_pc_o == m_val[h]),
          "R8 flush", {31'd0, flush_o, redirect_pc_o}, {31'd0, e_fl, m_val[h]});
    // R3 R9 R10 lookup
    t = m_tag[lr];
    if (!m_busy[lr]) begin l_rdy = 1; l_val = m_rf[lr]; end
    else if (m_done[t]) begin l_rdy = 1; l_val = m_val[t]; end
    else if (cv && ct == t) begin l_rdy = 1; l_val = cval; end
    else begin l_rdy = 0; l_val = 0; end
    check(look_ready_o == l_rdy && (l_rdy ? look_val_o == l_val : look_tag_o == 3'(t)),
          "R3 R9 R10 lookup", {look_ready_o, look_tag_o, 28'd0, look_val_o},
          {l_rdy, 3'(t), 28'd0, l_val});
    // advance reference
    if (hok) begin
      if (hk == 0) begin
        m_rf[m_dst[h]] = m_val[h];
        if (m_busy[m_dst[h]] && m_tag[m_dst[h]] == h) m_busy[m_dst[h]] = 0;
      end
      m_vld[h] = 0;
    end
    if (e_fl) begin
      for (int i = 0; i < D; i++) begin m_vld[i] = 0; m_done[i] = 0; m_adone[i] = 0; m_mis[i] = 0; end
      for (int r = 0; r < NR; r++) m_busy[r] = 0;
      m_head = (h + 1) % D; m_tail = m_head; m_cnt = 0;
    end else begin
      if (hok) begin m_head = (h + 1) % D; m_cnt--; end
      if (cv && m_vld[ct] && !m_done[ct]) begin
        m_done[ct] = 1; m_val[ct] = cval; m_mis[ct] = cmis;
      end
      if (av && m_vld[at] && !m_adone[at]) begin
        m_adone[at] = 1; m_addr[at] = aaddr;
      end
      if (iv && !full) begin
        m_vld[m_tail] = 1; m_kind[m_tail] = k; m_dst[m_tail] = d;
        m_done[m_tail] = 0; m_adone[m_tail] = 0; m_mis[m_tail] = 0;
        if (k == 0) begin m_busy[d] = 1; m_tag[d] = m_tail; end
        m_tail = (m_tail + 1) % D; m_cnt++;
      end
    end
    @(posedge clk_i);
  endtask

  task automatic idle(input int lr);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, lr);
  endtask

  initial begin
    #1_600_000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // R11 reset state
    @(negedge clk_i);
    look_reg_i = 4'd3;
    #1;
    check(issue_ready_o && !wb_en_o && !st_en_o && !flush_o, "R11 reset outputs",
          {wb_en_o, st_en_o, flush_o, issue_ready_o}, 64'h1);
    check(look_ready_o && look_val_o == 0, "R11 reset lookup", {look_ready_o, look_val_o}, {1'b1, 32'd0});
    @(posedge clk_i);

    // directed: two writers of r1, store, branch
    step(1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 1);         // tag0 r1
    step(1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 1);         // tag1 r1, lookup shows tag0
    step(1, 1, 0, 1, 1, 32'h1111, 0, 0, 0, 0, 1);  // store tag2; tag1 done first (R5)
    step(1, 2, 0, 1, 0, 32'h2222, 0, 0, 0, 0, 1);  // branch tag3; tag0 done
    idle(1);                                       // tag0 retires, r1 stays busy (R9)
    idle(1);                                       // tag1 retires
    step(0, 0, 0, 1, 2, 32'hABCD, 0, 0, 0, 0, 1);  // store data only (R4)
    idle(1);
    step(0, 0, 0, 0, 0, 0, 0, 1, 2, 32'h8000, 1);  // store address
    idle(1);                                       // store retires (R7)
    step(1, 0, 5, 1, 3, 32'h4000, 1, 0, 0, 0, 5);  // branch mispredicted; issue r5
    idle(5);                                       // flush; r5 busy then cleared (R8)
    step(1, 0, 6, 0, 0, 0, 0, 0, 0, 0, 6);         // issue in next cycle
    idle(6);

    // directed: fill to full, extra issue dropped (R2)
    for (int i = 0; i < D + 2; i++) step(1, 0, i % 4, 0, 0, 0, 0, 0, 0, 0, i % 4);
    // bus beat to a bogus tag already done and bypass lookup (R3 R10)
    step(0, 0, 0, 1, (m_head + 2) % D, 32'h5A5A, 0, 0, 0, 0, m_dst[(m_head + 2) % D]);
    step(0, 0, 0, 1, (m_head + 2) % D, 32'hDEAD, 0, 0, 0, 0, m_dst[(m_head + 2) % D]);
    for (int i = 0; i < D; i++) begin
      step(0, 0, 0, 1, (m_head + i) % D, 32'h100 + 32'(i), 0, 0, 0, 0, i % 4);
    end
    repeat (D + 2) idle(2);

    // constrained random
    for (int c = 0; c < 4000; c++) begin
      bit iv, cv, cm, av;
      int k, d, ct, at, lr;
      iv = ($urandom % 4) != 0;
      k  = $urandom % 3;
      d  = $urandom % NR;
      cv = $urandom % 2;
      ct = (m_cnt > 0 && ($urandom % 4) != 0) ? (m_head + $urandom % m_cnt) % D : $urandom % D;
      cm = ($urandom % 8) == 0;
      av = $urandom % 2;
      at = (m_cnt > 0) ? (m_head + $urandom % m_cnt) % D : $urandom % D;
      lr = $urandom % NR;
      step(iv, k, d, cv, ct, $urandom, cm, av, at, $urandom, lr);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule